// File: doc/BRIEF.md
# Indirect-Access General Purpose I/O Unit

This block provides 22 general purpose I/O pins in three groups of up to eight: pins 10-17, pins 20-25 and pins 30-37. A host reaches the pin data through two byte-wide ports, an index port and a data port. A select register decides where that pair sits in the host address space and whether it responds at all. The index port holds the number of the data group being accessed. The data port then reads or writes that group.

Each pin also has its own configuration byte, loaded through a separate configuration write port. The byte sets the pin's direction and whether its polarity is inverted. It can also hand the pin over to a special-function source, which then drives the pin's output and output enable directly.

The pin vectors are 24 bits wide, one byte per group. The two positions that group two lacks (vector bits 15:14) are never driven and read as zero.

Top module: `ixgpio_top`

## Requirements
- R1: After reset, every pin is a non-inverted GPIO input, so `pin_oe` and `pin_out` are all zero. The select register is cleared, which leaves the index/data pair disabled.
- R2: The select register is written through the configuration port at address 0x03. While its bit 7 is 0, host writes to the pair change nothing and host reads return 0x00.
- R3: Select bits 1:0 place the index/data port pair at one of four locations: 0 → 0xE0/0xE1, 1 → 0xE2/0xE3, 2 → 0xE4/0xE5, 3 → 0xEA/0xEB. Any other host address reads 0x00.
- R4: A read of the index port returns the index last written. Through the data port, index 0x01 reaches pins 10-17, 0x02 reaches pins 20-25 and 0x03 reaches pins 30-37. Any other index reads 0x00 and ignores writes.
- R5: A pin's bit within its data byte is its number modulo 10. In group 0x02, bits 7:6 read as 0 and ignore writes, and vector bits 15:14 of `pin_out` and `pin_oe` stay 0.
- R6: Configuration bit 0 set makes the pin an input (`pin_oe` 0). Its data bit then reads `pin_in`, inverted when configuration bit 1 is set.
- R7: Configuration bits 0 and 3 clear make the pin an output: `pin_oe` is 1 and `pin_out` is the latched data bit, inverted when bit 1 is set. Its data bit reads back the latched value, not inverted.
- R8: Configuration bit 3 set makes `pin_out` and `pin_oe` follow `sf_out` and `sf_oe`, whatever bits 0 and 1 hold. Its data bit reads the raw `pin_in` level.
- R9: Configuration bytes sit at 0xE0-0xE7 (pins 10-17), 0xE8-0xED (pins 20-25) and 0xF5-0xFC (pins 30-37). Configuration writes to other addresses, apart from 0x03, have no effect.
- R10: `bus_rdata` shows the read result in the cycle after `bus_rd` is sampled high, and is 0x00 in the cycle after any cycle with no read.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Host address |
| bus_wr | input | 1 | Host write strobe |
| bus_wdata | input | 8 | Host write data |
| bus_rd | input | 1 | Host read strobe |
| bus_rdata | output | 8 | Registered host read data |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte address (0x03 = select register) |
| cfg_wdata | input | 8 | Configuration byte value |
| pin_in | input | 24 | Pin levels, one byte per group |
| pin_out | output | 24 | Pin drive values |
| pin_oe | output | 24 | Pin output enables |
| sf_out | input | 24 | Special-function drive values |
| sf_oe | input | 24 | Special-function output enables |

## Verification
Some properties are checked on every cycle. The absent pin positions are never driven, and special-function pins track their sources. Non-special pins have an output enable that matches their direction bit. A read while the pair is disabled yields zero, as does any cycle with no read.

Other behaviour only the bench scenarios can show. This covers the four pair locations and the index-to-group mapping. It also covers input inversion, which applies on read but not to output readback, and the decoding of configuration addresses, including the holes in that map.

// File: rtl/ixg_pkg.sv
package ixg_pkg;

    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] SEL_REG_ADDR = 8'h03;
    localparam int SEL_EN_BIT  = 7;

    localparam int CB_INP  = 0;
    localparam int CB_INV  = 1;
    localparam int CB_SPEC = 3;

    typedef struct packed {
        logic       en;
        logic [1:0] pair;
    } sel_t;

    typedef struct packed {
        logic special;
        logic inv;
        logic inp;
    } pin_cfg_t;

    localparam pin_cfg_t CFG_RST = '{special: 1'b0, inv: 1'b0, inp: 1'b1};

    function automatic logic [ADDR_W-1:0] pair_base(input logic [1:0] p);
        case (p)
            2'd0:    return 8'hE0;
            2'd1:    return 8'hE2;
            2'd2:    return 8'hE4;
            default: return 8'hEA;
        endcase
    endfunction

    function automatic logic [ADDR_W-1:0] cfg_base(input int g);
        case (g)
            0:       return 8'hE0;
            1:       return 8'hE8;
            default: return 8'hF5;
        endcase
    endfunction

    function automatic pin_cfg_t cfg_decode(input logic [7:0] d);
        return '{special: d[CB_SPEC], inv: d[CB_INV], inp: d[CB_INP]};
    endfunction

endpackage

// File: rtl/ixg_cfg_bank.sv
module ixg_cfg_bank
    import ixg_pkg::*;
#(
    parameter int N_GRP = 3,
    parameter int GRP_W = 8,
    parameter logic [N_GRP*GRP_W-1:0] PIN_MASK = '1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cfg_we,
    input  logic [ADDR_W-1:0]       cfg_addr,
    input  logic [7:0]              cfg_wdata,
    output sel_t                    sel,
    output logic [N_GRP*GRP_W-1:0]  spec_v,
    output logic [N_GRP*GRP_W-1:0]  inv_v,
    output logic [N_GRP*GRP_W-1:0]  inp_v
);

    logic unused_bits;
    assign unused_bits = ^{cfg_wdata[6:4], cfg_wdata[2]};

    sel_t sel_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
        end else if (cfg_we && cfg_addr == SEL_REG_ADDR) begin
            sel_q <= '{en: cfg_wdata[SEL_EN_BIT], pair: cfg_wdata[1:0]};
        end
    end

    assign sel = sel_q;

    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        for (genvar b = 0; b < GRP_W; b++) begin : g_bit
            localparam int P = g * GRP_W + b;
            if (PIN_MASK[P]) begin : g_live
                pin_cfg_t c_q;
                logic     hit;
                assign hit = cfg_we && (cfg_addr == cfg_base(g) + ADDR_W'(b));
                always_ff @(posedge clk) begin
                    if (rst)      c_q <= CFG_RST;
                    else if (hit) c_q <= cfg_decode(cfg_wdata);
                end
                assign spec_v[P] = c_q.special;
                assign inv_v[P]  = c_q.inv;
                assign inp_v[P]  = c_q.inp;
            end else begin : g_dead
                assign spec_v[P] = 1'b0;
                assign inv_v[P]  = 1'b0;
                assign inp_v[P]  = 1'b1;
            end
        end
    end

endmodule

// File: rtl/ixg_pin_mux.sv
module ixg_pin_mux #(
    parameter int N_PIN = 24,
    parameter logic [N_PIN-1:0] PIN_MASK = '1
) (
    input  logic [N_PIN-1:0] pin_in,
    input  logic [N_PIN-1:0] sf_out,
    input  logic [N_PIN-1:0] sf_oe,
    input  logic [N_PIN-1:0] latch,
    input  logic [N_PIN-1:0] spec_v,
    input  logic [N_PIN-1:0] inv_v,
    input  logic [N_PIN-1:0] inp_v,
    output logic [N_PIN-1:0] pin_out,
    output logic [N_PIN-1:0] pin_oe,
    output logic [N_PIN-1:0] lvl
);

    for (genvar i = 0; i < N_PIN; i++) begin : g_pin
        if (PIN_MASK[i]) begin : g_live
            logic gp_drive;
            assign gp_drive   = latch[i] ^ inv_v[i];
            assign pin_oe[i]  = spec_v[i] ? sf_oe[i]  : ~inp_v[i];
            assign pin_out[i] = spec_v[i] ? sf_out[i] : (~inp_v[i] & gp_drive);
            assign lvl[i]     = spec_v[i] ? pin_in[i]
                              : (inp_v[i] ? (pin_in[i] ^ inv_v[i]) : latch[i]);
        end else begin : g_dead
            logic unused_b;
            assign unused_b   = pin_in[i] ^ sf_out[i] ^ sf_oe[i] ^ latch[i]
                              ^ spec_v[i] ^ inv_v[i] ^ inp_v[i];
            assign pin_oe[i]  = 1'b0;
            assign pin_out[i] = 1'b0;
            assign lvl[i]     = 1'b0;
        end
    end

endmodule

// File: rtl/ixg_host_port.sv
module ixg_host_port
    import ixg_pkg::*;
#(
    parameter int N_GRP = 3,
    parameter int GRP_W = 8,
    parameter logic [N_GRP*GRP_W-1:0] PIN_MASK = '1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  sel_t                    sel,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic                    bus_wr,
    input  logic [GRP_W-1:0]        bus_wdata,
    input  logic                    bus_rd,
    output logic [GRP_W-1:0]        bus_rdata,
    input  logic [N_GRP*GRP_W-1:0]  lvl,
    output logic [N_GRP*GRP_W-1:0]  latch
);

    logic [ADDR_W-1:0] base;
    logic              hit_idx;
    logic              hit_dat;
    logic [GRP_W-1:0]  idx_q;
    logic [GRP_W-1:0]  rd_val;
    logic [GRP_W-1:0]  rdata_q;

    assign base    = pair_base(sel.pair);
    assign hit_idx = sel.en && (bus_addr == base);
    assign hit_dat = sel.en && (bus_addr == base + ADDR_W'(1));

    always_ff @(posedge clk) begin
        if (rst)                    idx_q <= '0;
        else if (bus_wr && hit_idx) idx_q <= bus_wdata;
    end

    for (genvar g = 0; g < N_GRP; g++) begin : g_lat
        localparam logic [GRP_W-1:0] GM = PIN_MASK[g*GRP_W +: GRP_W];
        always_ff @(posedge clk) begin
            if (rst) begin
                latch[g*GRP_W +: GRP_W] <= '0;
            end else if (bus_wr && hit_dat && idx_q == GRP_W'(g + 1)) begin
                latch[g*GRP_W +: GRP_W] <= bus_wdata & GM;
            end
        end
    end

    always_comb begin
        rd_val = '0;
        if (hit_idx) begin
            rd_val = idx_q;
        end else if (hit_dat) begin
            for (int g = 0; g < N_GRP; g++) begin
                if (idx_q == GRP_W'(g + 1)) rd_val = lvl[g*GRP_W +: GRP_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         rdata_q <= '0;
        else if (bus_rd) rdata_q <= rd_val;
        else             rdata_q <= '0;
    end

    assign bus_rdata = rdata_q;

endmodule

// File: rtl/ixgpio_top.sv
module ixgpio_top
    import ixg_pkg::*;
#(
    parameter int N_GRP = 3,
    parameter int GRP_W = 8,
    parameter logic [N_GRP*GRP_W-1:0] PIN_MASK = 24'hFF3FFF
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [7:0]              bus_addr,
    input  logic                    bus_wr,
    input  logic [GRP_W-1:0]        bus_wdata,
    input  logic                    bus_rd,
    output logic [GRP_W-1:0]        bus_rdata,
    input  logic                    cfg_we,
    input  logic [7:0]              cfg_addr,
    input  logic [7:0]              cfg_wdata,
    input  logic [N_GRP*GRP_W-1:0]  pin_in,
    output logic [N_GRP*GRP_W-1:0]  pin_out,
    output logic [N_GRP*GRP_W-1:0]  pin_oe,
    input  logic [N_GRP*GRP_W-1:0]  sf_out,
    input  logic [N_GRP*GRP_W-1:0]  sf_oe
);

    localparam int N_PIN = N_GRP * GRP_W;

    sel_t             sel_q;
    logic [N_PIN-1:0] spec_v;
    logic [N_PIN-1:0] inv_v;
    logic [N_PIN-1:0] inp_v;
    logic [N_PIN-1:0] latch;
    logic [N_PIN-1:0] lvl;

    ixg_cfg_bank #(.N_GRP(N_GRP), .GRP_W(GRP_W), .PIN_MASK(PIN_MASK)) u_cfg (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .sel(sel_q), .spec_v(spec_v), .inv_v(inv_v), .inp_v(inp_v)
    );

    ixg_host_port #(.N_GRP(N_GRP), .GRP_W(GRP_W), .PIN_MASK(PIN_MASK)) u_host (
        .clk(clk), .rst(rst), .sel(sel_q),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .lvl(lvl), .latch(latch)
    );

    ixg_pin_mux #(.N_PIN(N_PIN), .PIN_MASK(PIN_MASK)) u_mux (
        .pin_in(pin_in), .sf_out(sf_out), .sf_oe(sf_oe), .latch(latch),
        .spec_v(spec_v), .inv_v(inv_v), .inp_v(inp_v),
        .pin_out(pin_out), .pin_oe(pin_oe), .lvl(lvl)
    );

endmodule

// File: rtl/ixg_chk.sv
module ixg_chk #(
    parameter int N_PIN = 24,
    parameter int GRP_W = 8,
    parameter logic [N_PIN-1:0] PIN_MASK = '1
) (
    input logic             clk,
    input logic             rst,
    input logic             bus_rd,
    input logic [GRP_W-1:0] bus_rdata,
    input logic [N_PIN-1:0] pin_out,
    input logic [N_PIN-1:0] pin_oe,
    input logic [N_PIN-1:0] sf_out,
    input logic [N_PIN-1:0] sf_oe,
    input logic             sel_en,
    input logic [N_PIN-1:0] spec_v,
    input logic [N_PIN-1:0] inp_v
);

    AST_RESET_ALL_INPUT: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pin_oe == '0 && pin_out == '0)); // R1

    AST_DISABLED_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !sel_en) |=> (bus_rdata == '0)); // R2

    AST_ABSENT_UNDRIVEN: assert property (@(posedge clk) disable iff (rst)
        ((pin_out | pin_oe) & ~PIN_MASK) == '0); // R5

    AST_GPIO_DIRECTION: assert property (@(posedge clk) disable iff (rst)
        ((pin_oe ^ ~inp_v) & ~spec_v & PIN_MASK) == '0); // R7

    AST_SPECIAL_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        (((pin_out ^ sf_out) | (pin_oe ^ sf_oe)) & spec_v & PIN_MASK) == '0); // R8

    AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> (bus_rdata == '0)); // R10

endmodule

bind ixgpio_top ixg_chk #(.N_PIN(N_PIN), .GRP_W(GRP_W), .PIN_MASK(PIN_MASK)) u_chk (
    .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .pin_out(pin_out), .pin_oe(pin_oe), .sf_out(sf_out), .sf_oe(sf_oe),
    .sel_en(sel_q.en), .spec_v(spec_v), .inp_v(inp_v)
);

// File: tb/sim_ixgpio_top.sv
module sim_ixgpio_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_rdata;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic [23:0] pin_in = 24'h25FF5A;
    logic [23:0] pin_out;
    logic [23:0] pin_oe;
    logic [23:0] sf_out = '0;
    logic [23:0] sf_oe = '0;

    always #4 clk = ~clk;

    ixgpio_top u0 (
        .clk(clk), .rst(rst),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .sf_out(sf_out), .sf_oe(sf_oe)
    );

    int n_chk = 0, n_fail = 0, m_chk = 0, m_fail = 0;
    bit finished = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic       took = 1'b0;

    // scoreboard monitor: a read issued before the last posedge is compared now
    always @(posedge clk) took <= bus_rd;
    always @(negedge clk) begin
        if (took && exp_q.size() > 0) begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            m_chk++;
            if (bus_rdata !== e) begin
                m_fail++;
                $display("FAIL %s: bus_rdata actual %02h expected %02h", t, bus_rdata, e);
            end
        end
    end

    task automatic chk(input string t, input logic [23:0] act, input logic [23:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %06h expected %06h", t, act, exp);
        end
    endtask

    task automatic cfg_wr(input logic [7:0] a, input logic [7:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic host_wr(input logic [7:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic host_rd(input logic [7:0] a, input logic [7:0] e, input string t);
        bus_rd = 1'b1; bus_addr = a;
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", (n_chk + m_chk) - (n_fail + m_fail), n_chk + m_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 pin_oe", pin_oe, 24'h0);
        chk("R1 pin_out", pin_out, 24'h0);
        host_rd(8'hE1, 8'h00, "R1 pair disabled");

        // R2 writes ignored while disabled
        host_wr(8'hE0, 8'h01);
        cfg_wr(8'h03, 8'h80);
        host_rd(8'hE0, 8'h00, "R2 index unchanged");

        // R4 index readback and group mapping, R6 plain input read
        host_wr(8'hE0, 8'h01);
        host_rd(8'hE0, 8'h01, "R4 index readback");
        host_rd(8'hE1, 8'h5A, "R6 group1 inputs");
        host_wr(8'hE0, 8'h02);
        host_rd(8'hE1, 8'h3F, "R5 group2 top bits zero");
        host_wr(8'hE0, 8'h03);
        host_rd(8'hE1, 8'h25, "R4 group3 inputs");

        // R6 inverted input pin 11
        cfg_wr(8'hE1, 8'h03);
        host_wr(8'hE0, 8'h01);
        host_rd(8'hE1, 8'h58, "R6 inverted input");

        // R7 output pin 10
        cfg_wr(8'hE0, 8'h00);
        chk("R7 oe pin10", pin_oe, 24'h000001);
        host_wr(8'hE1, 8'hFF);
        chk("R7 out pin10", pin_out, 24'h000001);
        host_rd(8'hE1, 8'h59, "R7 output readback");
        cfg_wr(8'hE0, 8'h02);
        chk("R7 inverted out", pin_out, 24'h000000);
        host_rd(8'hE1, 8'h59, "R7 readback not inverted");

        // R5 pin 25 output, unused bits ignored
        cfg_wr(8'hED, 8'h00);
        host_wr(8'hE0, 8'h02);
        host_wr(8'hE1, 8'hFF);
        chk("R5 oe", pin_oe, 24'h002001);
        chk("R5 out", pin_out, 24'h002000);
        host_rd(8'hE1, 8'h3F, "R5 group2 readback");

        // R8 special function on pin 30
        cfg_wr(8'hF5, 8'h0B);
        sf_out = 24'h010000; sf_oe = 24'h010000;
        #1;
        chk("R8 sf out", pin_out, 24'h012000);
        chk("R8 sf oe", pin_oe, 24'h012001);
        @(negedge clk);
        host_wr(8'hE0, 8'h03);
        host_rd(8'hE1, 8'h25, "R8 raw readback");
        sf_out = 24'h0;
        #1;
        chk("R8 sf out low", pin_out, 24'h002000);
        @(negedge clk);

        // R9 configuration address holes, pin 37
        cfg_wr(8'hEE, 8'h00);
        cfg_wr(8'hF4, 8'h00);
        chk("R9 holes ignored", pin_oe, 24'h012001);
        cfg_wr(8'hFC, 8'h00);
        chk("R9 pin37 config", pin_oe, 24'h812001);
        host_wr(8'hE1, 8'h80);
        chk("R9 pin37 out", pin_out, 24'h802000);
        host_rd(8'hE1, 8'hA5, "R9 group3 mixed");

        // R3 relocate the pair
        cfg_wr(8'h03, 8'h83);
        host_rd(8'hE0, 8'h00, "R3 old location dead");
        host_rd(8'hEA, 8'h03, "R3 EA index");
        host_wr(8'hEA, 8'h01);
        host_rd(8'hEB, 8'h59, "R3 EB data");
        cfg_wr(8'h03, 8'h82);
        host_rd(8'hE4, 8'h01, "R3 E4 index");

        // R4 unmapped index
        host_wr(8'hE4, 8'h05);
        host_rd(8'hE5, 8'h00, "R4 unmapped index");

        // R10 idle read data
        @(negedge clk);
        chk("R10 idle rdata", {16'h0, bus_rdata}, 24'h0);

        // R2 disable again: writes dropped
        cfg_wr(8'h03, 8'h02);
        host_wr(8'hE4, 8'h03);
        host_wr(8'hE5, 8'h00);
        chk("R2 latch kept", pin_out, 24'h802000);
        cfg_wr(8'h03, 8'h82);
        host_rd(8'hE4, 8'h05, "R2 index kept");

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule